// File: doc/BRIEF.md
# Stack Processor Fetch and Address Unit

This block forms the memory address of a small 16-bit stack processor and sequences the instructions it fetches. The memory address is a register. An outside controller picks, one cycle ahead, where the next address comes from. The choices are the saved instruction pointer, the A register, the top of the return stack, the A register plus an inline operand, and the current address plus one. Nothing sits between the address register and the memory port. When the bus leaves the program for a data access, the address that follows the current one is parked in the instruction pointer. The controller brings it back later with a single select.

Fetched words come in two kinds. A word with the top bit set is a call: the block steers the bus to the 15-bit target and asks for a return-stack push of the address after the call. Any other word carries three 5-bit opcodes. The block presents them one at a time and advances on the controller's step strobe. It raises `fetch_o` once the last opcode has been issued, or when a taken jump throws away the opcodes that remain.

Top module: `stk_fetch_unit`

## Requirements
- R1: A synchronous active-low reset clears the address register and the instruction pointer to 0. It selects slot 0, with `fetch_o`=1 and `op_valid_o`=0.
- R2: `src_sel_i` is one-hot. With bit 4 (increment) set, the address becomes the current address plus one at the next edge, wrapping modulo 2^16. With no bit set, the address holds.
- R3: Bit 1 loads `a_reg_i`, bit 2 loads `r_top_i`, and bit 3 loads `a_reg_i + inline_i` modulo 2^16, each at the next edge.
- R4: A non-jump select of bit 1, 2 or 3 stores the current address plus one in the instruction pointer. Bit 0 loads the address from the instruction pointer. Increment, bit 0, no select, jumps and calls leave the instruction pointer unchanged.
- R5: A packed word holds slot 0 in bits 14:10, slot 1 in bits 9:5 and slot 2 in bits 4:0. The slots appear on `op_o` in that order, with `slot_o` giving the index, and advance on each `step_i`. A step on slot 2 raises `fetch_o` at the next edge. Without a step, the slot holds.
- R6: While `fetch_o`=1, a word with bit 15 set drives `rpush_o`=1 in the same cycle. In that cycle `rpush_data_o` is the address plus one and `call_target_o` is bits 14:0. The next address is the zero-extended target, whatever `src_sel_i` is, and `fetch_o` stays 1.
- R7: `jump_i` while opcodes are pending discards them: `fetch_o` is 1 after the edge. The instruction pointer is not written.
- R8: While `fetch_o`=1, `step_i` and `jump_i` have no effect. A packed word present on `mem_rdata_i` is always taken, starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel_i | input | 5 | One-hot source for the next address |
| jump_i | input | 1 | Selected source is a control transfer |
| step_i | input | 1 | Current opcode consumed |
| a_reg_i | input | 16 | A register value |
| r_top_i | input | 16 | Return stack top value |
| inline_i | input | 16 | Inline operand added to A |
| mem_rdata_i | input | 16 | Word at the current address |
| mem_addr_o | output | 16 | Registered memory address |
| fetch_o | output | 1 | Block is waiting for an instruction word |
| op_valid_o | output | 1 | `op_o` holds a pending opcode |
| op_o | output | 5 | Opcode of the current slot |
| slot_o | output | 2 | Index of the current slot |
| rpush_o | output | 1 | Return-stack push request (call) |
| rpush_data_o | output | 16 | Return address to push |
| call_target_o | output | 15 | Target of the call word |

## Verification
The bench parks the bus on a data address, steps it along, and then resumes. A design that saved the pointer on every cycle, or on increments, would return to the wrong word. It runs jumps and calls and checks that neither touches the saved pointer, since a design that got this wrong would corrupt later resumes. It drives a step and a jump on the very cycle a word arrives, because a design that honoured them would skip slot 0 or drop the word. It also pushes an operand sum past 0xFFFF and checks that only the carry out of bit 15 is dropped.

// File: rtl/stk_fetch_pkg.sv
// Shared constants for the fetch and address unit.
// Assumes the select vector uses the bit positions listed here.
package stk_fetch_pkg;
    localparam int NSRC = 5;

    typedef enum int {
        SRC_IP   = 0,
        SRC_AREG = 1,
        SRC_RTOP = 2,
        SRC_OFS  = 3,
        SRC_INC  = 4
    } src_idx_e;
endpackage

// File: rtl/fa_slot_seq.sv
// Instruction word holder and slot sequencer.
// Takes the word on mem data while waiting for a fetch. A call word is
// reported and not stored. A packed word is split into SLOTS fields of
// OP_W bits, taken from the top, below the call flag.
// Assumes the controller keeps the bus on program memory while fetch is high.
module fa_slot_seq #(
    parameter int WORD_W = 16,
    parameter int OP_W   = 5,
    parameter int SLOTS  = 3,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CALL_W = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              step_i,
    input  logic              jump_i,
    output logic              need_o,
    output logic              call_take_o,
    output logic [CALL_W-1:0] call_tgt_o,
    output logic              jump_take_o,
    output logic [OP_W-1:0]   op_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [WORD_W-1:0] ir_q;
    logic [SLOT_W-1:0] slot_q;
    logic              need_q;
    logic [OP_W-1:0]   field [SLOTS];

    // Call decode: flag bit set on a word that arrives while waiting.
    always_comb begin
        call_take_o = need_q && word_i[WORD_W-1];
        call_tgt_o  = word_i[CALL_W-1:0];
        jump_take_o = jump_i && !need_q;
    end

    // Slice the held word into its opcode fields, slot 0 at the top.
    for (genvar k = 0; k < SLOTS; k++) begin : g_field
        assign field[k] = ir_q[CALL_W-1-k*OP_W -: OP_W];
    end

    // Present the field picked by the slot counter.
    always_comb begin
        op_o = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_q == SLOT_W'(k)) op_o = field[k];
        end
    end

    // Word load, slot advance and discard on jumps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            slot_q <= '0;
            need_q <= 1'b1;
        end else if (need_q) begin
            if (!word_i[WORD_W-1]) begin
                ir_q   <= word_i;
                slot_q <= '0;
                need_q <= 1'b0;
            end
        end else if (jump_i) begin
            slot_q <= '0;
            need_q <= 1'b1;
        end else if (step_i) begin
            if (slot_q == LAST_SLOT) begin
                slot_q <= '0;
                need_q <= 1'b1;
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    assign need_o = need_q;
    assign slot_o = slot_q;

    // R5: the slot index never leaves its range.
    always_comb begin
        a_r5_slot_range: assert (!rst_n || slot_q <= LAST_SLOT);
    end

    a_r5_last_step_fetches: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !need_q && slot_q == LAST_SLOT) |=> need_q);

    a_r6_call_keeps_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (need_q && word_i[WORD_W-1]) |=> need_q);

    a_r7_jump_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !need_q) |=> need_q);

    a_r8_load_at_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (need_q && !word_i[WORD_W-1]) |=> (!need_q && slot_q == '0));
endmodule

// File: rtl/fa_next_addr.sv
// Next-address selector and instruction pointer update, purely combinational.
// Call has priority over the select. Assumes the select is one-hot or zero.
module fa_next_addr
    import stk_fetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CALL_W = 15
) (
    input  logic [NSRC-1:0]   sel_i,
    input  logic [ADDR_W-1:0] addr_q_i,
    input  logic [ADDR_W-1:0] ip_q_i,
    input  logic [ADDR_W-1:0] a_reg_i,
    input  logic [ADDR_W-1:0] r_top_i,
    input  logic [ADDR_W-1:0] inline_i,
    input  logic              call_take_i,
    input  logic [CALL_W-1:0] call_tgt_i,
    input  logic              jump_take_i,
    output logic [ADDR_W-1:0] addr_d_o,
    output logic [ADDR_W-1:0] ip_d_o,
    output logic [ADDR_W-1:0] addr_inc_o
);
    logic off_prog;

    // Choose the address for the next memory cycle.
    always_comb begin
        addr_inc_o = addr_q_i + ADDR_W'(1);
        if (call_take_i)         addr_d_o = ADDR_W'(call_tgt_i);
        else if (sel_i[SRC_IP])  addr_d_o = ip_q_i;
        else if (sel_i[SRC_AREG]) addr_d_o = a_reg_i;
        else if (sel_i[SRC_RTOP]) addr_d_o = r_top_i;
        else if (sel_i[SRC_OFS])  addr_d_o = a_reg_i + inline_i;
        else if (sel_i[SRC_INC])  addr_d_o = addr_inc_o;
        else                      addr_d_o = addr_q_i;
    end

    // Park the following address when a non-program source takes the bus.
    always_comb begin
        off_prog = sel_i[SRC_AREG] | sel_i[SRC_RTOP] | sel_i[SRC_OFS];
        ip_d_o   = (off_prog && !call_take_i && !jump_take_i) ? addr_inc_o : ip_q_i;
    end
endmodule

// File: rtl/fa_ptr_regs.sv
// Address and instruction pointer registers. The address register drives
// the memory port directly. Assumes next values come from fa_next_addr.
module fa_ptr_regs
    import stk_fetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CALL_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   sel_i,
    input  logic              call_take_i,
    input  logic [CALL_W-1:0] call_tgt_i,
    input  logic [ADDR_W-1:0] addr_d_i,
    input  logic [ADDR_W-1:0] ip_d_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [ADDR_W-1:0] ip_q_o
);
    // Latch both pointers on the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q_o <= '0;
            ip_q_o   <= '0;
        end else begin
            addr_q_o <= addr_d_i;
            ip_q_o   <= ip_d_i;
        end
    end

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_i));

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i[SRC_INC] && !call_take_i) |=> addr_q_o == $past(addr_q_o) + ADDR_W'(1));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0 && !call_take_i) |=> $stable(addr_q_o));

    a_r4_ip_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i[SRC_AREG] || sel_i[SRC_RTOP] || sel_i[SRC_OFS]) |=> $stable(ip_q_o));

    a_r6_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        call_take_i |=> addr_q_o == ADDR_W'($past(call_tgt_i)));
endmodule

// File: rtl/stk_fetch_unit.sv
// Fetch and memory address unit of a 16-bit stack processor.
// Assumes a controller picks the next source a cycle ahead and that memory
// returns the word at mem_addr_o within the same cycle.
module stk_fetch_unit
    import stk_fetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 16,
    parameter int OP_W   = 5,
    parameter int SLOTS  = 3,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CALL_W = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_sel_i,
    input  logic              jump_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] a_reg_i,
    input  logic [ADDR_W-1:0] r_top_i,
    input  logic [ADDR_W-1:0] inline_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              fetch_o,
    output logic              op_valid_o,
    output logic [OP_W-1:0]   op_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              rpush_o,
    output logic [ADDR_W-1:0] rpush_data_o,
    output logic [CALL_W-1:0] call_target_o
);
    logic              need, call_take, jump_take;
    logic [CALL_W-1:0] call_tgt;
    logic [ADDR_W-1:0] addr_q, ip_q, addr_d, ip_d, addr_inc;

    fa_slot_seq #(.WORD_W(WORD_W), .OP_W(OP_W), .SLOTS(SLOTS)) u_seq (
        .clk(clk), .rst_n(rst_n), .word_i(mem_rdata_i), .step_i(step_i),
        .jump_i(jump_i), .need_o(need), .call_take_o(call_take),
        .call_tgt_o(call_tgt), .jump_take_o(jump_take), .op_o(op_o),
        .slot_o(slot_o)
    );

    fa_next_addr #(.ADDR_W(ADDR_W), .CALL_W(CALL_W)) u_next (
        .sel_i(src_sel_i), .addr_q_i(addr_q), .ip_q_i(ip_q), .a_reg_i(a_reg_i),
        .r_top_i(r_top_i), .inline_i(inline_i), .call_take_i(call_take),
        .call_tgt_i(call_tgt), .jump_take_i(jump_take), .addr_d_o(addr_d),
        .ip_d_o(ip_d), .addr_inc_o(addr_inc)
    );

    fa_ptr_regs #(.ADDR_W(ADDR_W), .CALL_W(CALL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel_i(src_sel_i), .call_take_i(call_take),
        .call_tgt_i(call_tgt), .addr_d_i(addr_d), .ip_d_i(ip_d),
        .addr_q_o(addr_q), .ip_q_o(ip_q)
    );

    // Drive the outward-facing status and push request.
    always_comb begin
        mem_addr_o    = addr_q;
        fetch_o       = need;
        op_valid_o    = !need;
        rpush_o       = call_take;
        rpush_data_o  = addr_inc;
        call_target_o = call_tgt;
    end
endmodule

// File: tb/stk_fetch_unit_tb.sv
// Directed bench for stk_fetch_unit: one task per scenario.
module stk_fetch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_sel_i = '0;
    logic        jump_i = 1'b0, step_i = 1'b0;
    logic [15:0] a_reg_i = '0, r_top_i = '0, inline_i = '0, mem_rdata_i = '0;
    logic [15:0] mem_addr_o, rpush_data_o;
    logic        fetch_o, op_valid_o, rpush_o;
    logic [4:0]  op_o;
    logic [1:0]  slot_o;
    logic [14:0] call_target_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    localparam logic [4:0] S_IP = 5'b00001, S_A = 5'b00010, S_R = 5'b00100,
                           S_OFS = 5'b01000, S_INC = 5'b10000, S_NONE = 5'b00000;

    stk_fetch_unit u_dut (.*);

    always #10 clk = ~clk;

    // Compare one value and log a mismatch.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one clock edge and settle past it.
    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // Apply reset with idle inputs.
    task automatic do_reset;
        rst_n = 1'b0; src_sel_i = S_NONE; jump_i = 0; step_i = 0;
        a_reg_i = '0; r_top_i = '0; inline_i = '0; mem_rdata_i = '0;
        tick; tick;
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset;
        check("R1 addr", mem_addr_o, 0);
        check("R1 fetch", fetch_o, 1);
        check("R1 op_valid", op_valid_o, 0);
        check("R1 slot", slot_o, 0);
        src_sel_i = S_INC; tick;
        src_sel_i = S_IP;  tick;
        check("R1 ip cleared", mem_addr_o, 0);
    endtask

    task automatic t_seq;
        do_reset;
        src_sel_i = S_INC;
        tick; check("R2 inc 1", mem_addr_o, 1);
        tick; check("R2 inc 2", mem_addr_o, 2);
        src_sel_i = S_NONE;
        tick; check("R2 hold", mem_addr_o, 2);
        a_reg_i = 16'hFFFF; src_sel_i = S_A; tick;
        src_sel_i = S_INC; tick;
        check("R2 wrap", mem_addr_o, 0);
    endtask

    task automatic t_sources;
        do_reset;
        a_reg_i = 16'h1234; src_sel_i = S_A; tick;
        check("R3 A source", mem_addr_o, 16'h1234);
        r_top_i = 16'hBEEF; src_sel_i = S_R; tick;
        check("R3 R source", mem_addr_o, 16'hBEEF);
        a_reg_i = 16'hFFF0; inline_i = 16'h0020; src_sel_i = S_OFS; tick;
        check("R3 A+inline wrap", mem_addr_o, 16'h0010);
    endtask

    task automatic t_ipsave;
        do_reset;
        src_sel_i = S_INC; tick; tick;
        a_reg_i = 16'h0400; src_sel_i = S_A; tick;
        src_sel_i = S_INC; tick;
        check("R4 data walk", mem_addr_o, 16'h0401);
        src_sel_i = S_IP; tick;
        check("R4 resume", mem_addr_o, 3);
        r_top_i = 16'h0050; jump_i = 1; src_sel_i = S_R; tick;
        jump_i = 0;
        check("R7 jump addr", mem_addr_o, 16'h0050);
        src_sel_i = S_IP; tick;
        check("R7 no ip write", mem_addr_o, 3);
        a_reg_i = 16'h0900; src_sel_i = S_OFS; inline_i = 16'h0001; tick;
        src_sel_i = S_IP; tick;
        check("R4 second save", mem_addr_o, 4);
    endtask

    task automatic t_slots;
        do_reset;
        mem_rdata_i = 16'h0E3E; step_i = 1; tick;
        check("R8 step ignored, slot", slot_o, 0);
        check("R5 slot0 op", op_o, 3);
        check("R5 valid", op_valid_o, 1);
        tick;
        check("R5 slot1 op", op_o, 17);
        tick;
        check("R5 slot2 op", op_o, 30);
        check("R5 slot2 idx", slot_o, 2);
        src_sel_i = S_INC; tick;
        check("R5 fetch after slot2", fetch_o, 1);
        check("R5 next word addr", mem_addr_o, 1);
        step_i = 0; src_sel_i = S_NONE; mem_rdata_i = 16'h7FFF; tick;
        check("R5 new word op", op_o, 31);
        tick;
        check("R5 no step holds", slot_o, 0);
        check("R5 no step valid", op_valid_o, 1);
    endtask

    task automatic t_call;
        do_reset;
        mem_rdata_i = 16'h9ABC; src_sel_i = S_INC; #1;
        check("R6 push req", rpush_o, 1);
        check("R6 push data", rpush_data_o, 1);
        check("R6 target", call_target_o, 15'h1ABC);
        tick;
        check("R6 jump to target", mem_addr_o, 16'h1ABC);
        check("R6 still fetching", fetch_o, 1);
        mem_rdata_i = 16'h8042; src_sel_i = S_NONE; #1;
        check("R6 push data 2", rpush_data_o, 16'h1ABD);
        tick;
        check("R6 second target", mem_addr_o, 16'h0042);
        mem_rdata_i = 16'h0000; src_sel_i = S_IP; #1;
        check("R6 no push on packed", rpush_o, 0);
        tick;
        check("R6 ip unchanged by call", mem_addr_o, 0);
    endtask

    task automatic t_jump;
        do_reset;
        mem_rdata_i = 16'h0E3E; jump_i = 1; tick;
        check("R8 jump ignored while fetching", op_valid_o, 1);
        jump_i = 0; step_i = 1; tick;
        check("R7 at slot1", slot_o, 1);
        step_i = 0; jump_i = 1; a_reg_i = 16'h0300; src_sel_i = S_A; tick;
        jump_i = 0;
        check("R7 discard", fetch_o, 1);
        check("R7 target", mem_addr_o, 16'h0300);
        mem_rdata_i = 16'h0000; src_sel_i = S_IP; tick;
        check("R7 ip kept", mem_addr_o, 0);
    endtask

    // Stop a hung run and still report.
    initial begin
        #(20 * 200000);
        if (!done) begin
            check("watchdog expired (all R)", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_seq;
        t_sources;
        t_ipsave;
        t_slots;
        t_call;
        t_jump;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule